// File: doc/BRIEF.md
# Shared-Bus Accumulator Microcomputer

This block is a minimal 8-bit stored-program computer. All data moves over one internal 8-bit bus. The bus is fed by a 4-bit program counter, the RAM, the operand field of the instruction register, the accumulator and an adder/subtracter. A 12-bit control word from an internal sequencer enables at most one of these sources per clock. The same word selects the registers that capture the bus value at the next edge. The registers on the bus are a memory address register, a 16x8 RAM, an instruction register, an accumulator, a B register and an output register.

Before a run, the environment holds the synchronous clear high and fills the RAM through a byte write port. It then releases the clear. From that point the machine fetches and executes one instruction every six clocks, starting at address 0. It stops when it meets a halt instruction. The results are the 8-bit output register and a halted flag.

Top module: `acc_microcomputer`

## Requirements
- R1: An instruction byte carries the opcode in bits 7:4 and a RAM address in bits 3:0. The opcodes are 0x0 load, 0x1 add, 0x2 subtract, 0xE output and 0xF halt.
- R2: Load copies RAM[addr] into the accumulator. Add replaces the accumulator with acc + RAM[addr] modulo 256. Subtract replaces it with acc - RAM[addr] modulo 256. No carry or borrow is kept.
- R3: Output copies the accumulator into `out_port`. Counting from the first clock edge of instruction k (0-based, edge 1 after the clear is released), the new value is visible after edge 6k+4.
- R4: Every instruction takes exactly six clock edges. Instruction k starts at edge 6k+1 after the clear is released.
- R5: Halt raises `halted` after edge 6k+4 of its instruction k. `halted` then stays high and `out_port` stays stable until the next clear.
- R6: Opcodes other than the five defined ones change no register other than the program counter, and take the full six clocks.
- R7: The program counter wraps from address 15 to address 0 and continues fetching.
- R8: A clock edge with `rst` high forces `out_port` to 0 and `halted` to 0. It also clears the accumulator and the B register and restarts fetching at address 0.
- R9: A clock edge with `wr_en` high stores `wr_data` at RAM address `wr_addr`. This includes edges where `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear |
| wr_en | input | 1 | RAM preload write enable |
| wr_addr | input | 4 | RAM preload address |
| wr_data | input | 8 | RAM preload data |
| out_port | output | 8 | Output register |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench times the output and halt events to the exact edge. A sequencer that spent the wrong number of states on an instruction, or updated the output a state early or late, would miss those edges. Sums and differences are chosen to cross 255 and 0, so a design that saturated or kept extra width would give wrong values. Undefined opcodes sit between real instructions, where any stray write would corrupt the accumulator. A program that never halts checks the counter wrap: a counter that stuck at 15 or skipped ahead would miss the second pass. A clear in the middle of a run followed by a restart shows whether the accumulator was really zeroed.

// File: rtl/ubc_pkg.sv
package ubc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int OPC_W  = DATA_W - ADDR_W;
  localparam int NUM_T  = 6;
  localparam int NSRC   = 5;

  localparam logic [OPC_W-1:0] OPC_LDA = 4'h0;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'h2;
  localparam logic [OPC_W-1:0] OPC_OUT = 4'hE;
  localparam logic [OPC_W-1:0] OPC_HLT = 4'hF;

  // bus source index order used by the datapath mux
  localparam int SRC_PC  = 0;
  localparam int SRC_RAM = 1;
  localparam int SRC_IR  = 2;
  localparam int SRC_ACC = 3;
  localparam int SRC_ALU = 4;

  typedef struct packed {
    logic pc_inc;
    logic pc_drv;
    logic mar_ld;
    logic ram_drv;
    logic ir_ld;
    logic ir_drv;
    logic acc_ld;
    logic acc_drv;
    logic sub_sel;
    logic alu_drv;
    logic b_ld;
    logic out_ld;
  } ctrl_word_t;

  function automatic logic [DATA_W-1:0] alu_eval(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic sub);
    logic [DATA_W-1:0] r;
    if (sub) r = a - b;
    else     r = a + b;
    return r;
  endfunction

  function automatic logic [NSRC-1:0] bus_drivers(input ctrl_word_t c);
    logic [NSRC-1:0] d;
    d = '0;
    d[SRC_PC]  = c.pc_drv;
    d[SRC_RAM] = c.ram_drv;
    d[SRC_IR]  = c.ir_drv;
    d[SRC_ACC] = c.acc_drv;
    d[SRC_ALU] = c.alu_drv;
    return d;
  endfunction

  function automatic logic is_mem_op(input logic [OPC_W-1:0] op);
    return (op == OPC_LDA) || (op == OPC_ADD) || (op == OPC_SUB);
  endfunction
endpackage

// File: rtl/ubc_sequencer.sv
module ubc_sequencer
  import ubc_pkg::*;
#(
  parameter int T_STATES = NUM_T,
  parameter int OW       = OPC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OW-1:0]       opcode,
  output logic [T_STATES-1:0] tstate,
  output ctrl_word_t          cw,
  output logic                halted,
  output logic                halt_hit
);
  localparam logic [T_STATES-1:0] T_FIRST = T_STATES'(1);

  assign halt_hit = tstate[3] && (opcode == OPC_HLT) && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      tstate <= T_FIRST;
      halted <= 1'b0;
    end else if (!halted) begin
      tstate <= {tstate[T_STATES-2:0], tstate[T_STATES-1]};
      if (halt_hit) halted <= 1'b1;
    end
  end

  always_comb begin
    cw = '0;
    if (!halted) begin
      if (tstate[0]) begin
        cw.pc_drv = 1'b1;
        cw.mar_ld = 1'b1;
      end
      if (tstate[1]) cw.pc_inc = 1'b1;
      if (tstate[2]) begin
        cw.ram_drv = 1'b1;
        cw.ir_ld   = 1'b1;
      end
      if (tstate[3]) begin
        if (is_mem_op(opcode)) begin
          cw.ir_drv = 1'b1;
          cw.mar_ld = 1'b1;
        end else if (opcode == OPC_OUT) begin
          cw.acc_drv = 1'b1;
          cw.out_ld  = 1'b1;
        end
      end
      if (tstate[4]) begin
        if (opcode == OPC_LDA) begin
          cw.ram_drv = 1'b1;
          cw.acc_ld  = 1'b1;
        end else if (opcode == OPC_ADD || opcode == OPC_SUB) begin
          cw.ram_drv = 1'b1;
          cw.b_ld    = 1'b1;
        end
      end
      if (tstate[5]) begin
        if (opcode == OPC_ADD || opcode == OPC_SUB) begin
          cw.alu_drv = 1'b1;
          cw.acc_ld  = 1'b1;
          cw.sub_sel = (opcode == OPC_SUB);
        end
      end
    end
  end
endmodule

// File: rtl/ubc_memory.sv
module ubc_memory
  import ubc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mar_ld,
  input  logic [AW-1:0] bus_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] mar;

  always_ff @(posedge clk) begin
    if (rst)         mar <= '0;
    else if (mar_ld) mar <= bus_addr;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[mar];
endmodule

// File: rtl/ubc_datapath.sv
module ubc_datapath
  import ubc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_word_t    cw,
  input  logic [DW-1:0] ram_data,
  output logic [DW-1:0] bus,
  output logic [DW-AW-1:0] opcode,
  output logic [NSRC-1:0]  drv_en,
  output logic [DW-1:0] out_port
);
  logic [AW-1:0] pc;
  logic [DW-1:0] ir;
  logic [DW-1:0] acc;
  logic [DW-1:0] breg;
  logic [DW-1:0] alu_y;
  logic [DW-1:0] src   [NSRC];
  logic [DW-1:0] gated [NSRC];

  assign alu_y  = alu_eval(acc, breg, cw.sub_sel);
  assign opcode = ir[DW-1:AW];
  assign drv_en = bus_drivers(cw);

  assign src[SRC_PC]  = {{(DW-AW){1'b0}}, pc};
  assign src[SRC_RAM] = ram_data;
  assign src[SRC_IR]  = {{(DW-AW){1'b0}}, ir[AW-1:0]};
  assign src[SRC_ACC] = acc;
  assign src[SRC_ALU] = alu_y;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = drv_en[g] ? src[g] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | gated[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ir       <= '0;
      acc      <= '0;
      breg     <= '0;
      out_port <= '0;
    end else begin
      if (cw.pc_inc) pc       <= pc + 1'b1;
      if (cw.ir_ld)  ir       <= bus;
      if (cw.acc_ld) acc      <= bus;
      if (cw.b_ld)   breg     <= bus;
      if (cw.out_ld) out_port <= bus;
    end
  end
endmodule

// File: rtl/acc_microcomputer.sv
module acc_microcomputer
  import ubc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] out_port,
  output logic              halted
);
  ctrl_word_t        cw;
  logic [NUM_T-1:0]  tstate;
  logic [OPC_W-1:0]  opcode;
  logic [DATA_W-1:0] bus;
  logic [DATA_W-1:0] ram_data;
  logic [NSRC-1:0]   drv_en;
  logic              halt_hit;

  ubc_sequencer #(.T_STATES(NUM_T), .OW(OPC_W)) u_seq (
    .clk(clk), .rst(rst), .opcode(opcode), .tstate(tstate),
    .cw(cw), .halted(halted), .halt_hit(halt_hit)
  );

  ubc_memory #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .clk(clk), .rst(rst), .mar_ld(cw.mar_ld), .bus_addr(bus[ADDR_W-1:0]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(ram_data)
  );

  ubc_datapath #(.DW(DATA_W), .AW(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .cw(cw), .ram_data(ram_data), .bus(bus),
    .opcode(opcode), .drv_en(drv_en), .out_port(out_port)
  );
endmodule

// File: rtl/acc_microcomputer_chk.sv
module acc_microcomputer_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] drv_en,
  input logic [5:0] tstate,
  input logic [3:0] opcode,
  input logic       halted,
  input logic       halt_hit,
  input logic [7:0] out_port
);
  // R2
  bus_single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_en));

  // R4
  cycle_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && tstate[5]) |=> tstate[0]);

  // R3
  out_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_port) |-> $past(tstate[3]));

  // R5
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R5
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(out_port));

  // R5
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    halt_hit |=> halted);

  // R6
  undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((tstate[3] || tstate[4] || tstate[5]) && opcode != 4'h0 && opcode != 4'h1
      && opcode != 4'h2 && opcode != 4'hE) |-> (drv_en == 5'b0));

  // R8
  clear_chk: assert property (@(posedge clk)
    rst |=> (out_port == 8'h00 && !halted && tstate == 6'b000001));
endmodule

bind acc_microcomputer acc_microcomputer_chk u_chk (
  .clk(clk), .rst(rst), .drv_en(drv_en), .tstate(tstate), .opcode(opcode),
  .halted(halted), .halt_hit(halt_hit), .out_port(out_port)
);

// File: tb/acc_microcomputer_tb.sv
`timescale 1ns/1ps
module acc_microcomputer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] out_port;
  logic       halted;

  int checks = 0;
  int failures = 0;
  int edge_n = 0;
  logic [7:0] img [16];

  always #5 clk = ~clk;

  acc_microcomputer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_port(out_port), .halted(halted)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_img(input logic [7:0] fill);
    for (int i = 0; i < 16; i++) img[i] = fill;
  endtask

  // R9: write the whole image with clear held, one byte per edge
  task automatic load_and_start();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      wr_en = 1'b1; wr_addr = 4'(i); wr_data = img[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    edge_n = 0;
  endtask

  task automatic run_to(input int e);
    while (edge_n < e) begin
      @(posedge clk);
      edge_n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_port == 8'h00, "R8 reset out", out_port, 0);
    chk(halted == 1'b0, "R8 reset halted", halted, 0);
  endtask

  // R1 R2 R4 R5: 8 + 4 - 3 + 5
  task automatic t_arith();
    clear_img(8'h00);
    img[0] = 8'h0B; img[1] = 8'h1C; img[2] = 8'h2D; img[3] = 8'h1E;
    img[4] = 8'hE0; img[5] = 8'hF0;
    img[11] = 8'd8; img[12] = 8'd4; img[13] = 8'd3; img[14] = 8'd5;
    load_and_start();
    run_to(27);
    chk(out_port == 8'h00, "R3 out before T4", out_port, 0);
    run_to(28);
    chk(out_port == 8'd14, "R2 R1 arithmetic", out_port, 14);
    run_to(33);
    chk(halted == 1'b0, "R4 halt not early", halted, 0);
    run_to(34);
    chk(halted == 1'b1, "R5 halt on time", halted, 1);
  endtask

  // R2 R3: wrap both ways, two outputs
  task automatic t_wrap();
    clear_img(8'h00);
    img[0] = 8'h0E; img[1] = 8'h1F; img[2] = 8'hE0; img[3] = 8'h2D;
    img[4] = 8'hE0; img[5] = 8'hF0;
    img[13] = 8'd50; img[14] = 8'd200; img[15] = 8'd100;
    load_and_start();
    run_to(15);
    chk(out_port == 8'h00, "R3 first out not early", out_port, 0);
    run_to(16);
    chk(out_port == 8'd44, "R2 add wraps", out_port, 44);
    run_to(27);
    chk(out_port == 8'd44, "R3 second out not early", out_port, 44);
    run_to(28);
    chk(out_port == 8'd250, "R2 sub wraps", out_port, 250);
  endtask

  // R6 R5: undefined opcodes, then halt freeze
  task automatic t_undef();
    clear_img(8'h00);
    img[0] = 8'h0F; img[1] = 8'h30; img[2] = 8'h7A; img[3] = 8'hD5;
    img[4] = 8'hE0; img[5] = 8'hF0; img[15] = 8'd7;
    load_and_start();
    run_to(27);
    chk(out_port == 8'h00, "R6 nops take six clocks", out_port, 0);
    run_to(28);
    chk(out_port == 8'd7, "R6 acc untouched by nops", out_port, 7);
    run_to(33);
    chk(halted == 1'b0, "R6 halt not early", halted, 0);
    run_to(34);
    chk(halted == 1'b1, "R5 halt after nops", halted, 1);
    run_to(80);
    chk(halted == 1'b1, "R5 halt sticky", halted, 1);
    chk(out_port == 8'd7, "R5 out frozen", out_port, 7);
  endtask

  // R5: halt as the first instruction
  task automatic t_halt_first();
    clear_img(8'hF0);
    load_and_start();
    run_to(3);
    chk(halted == 1'b0, "R5 halt first not early", halted, 0);
    run_to(4);
    chk(halted == 1'b1, "R5 halt first", halted, 1);
  endtask

  // R7 then R8: counter wrap, mid-run clear and restart
  task automatic t_wrap_pc_and_clear();
    clear_img(8'h30);
    img[0] = 8'hE0; img[1] = 8'h1F;
    load_and_start();
    run_to(4);
    chk(out_port == 8'h00, "R7 first out zero", out_port, 0);
    run_to(99);
    chk(out_port == 8'h00, "R7 second pass not early", out_port, 0);
    run_to(100);
    chk(out_port == 8'h30, "R7 pc wraps to 0", out_port, 8'h30);
    run_to(110);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(out_port == 8'h00, "R8 clear out", out_port, 0);
    chk(halted == 1'b0, "R8 clear halted", halted, 0);
    rst = 1'b0;
    edge_n = 0;
    run_to(4);
    chk(out_port == 8'h00, "R8 acc cleared", out_port, 0);
    run_to(100);
    chk(out_port == 8'h30, "R8 restart at 0", out_port, 8'h30);
  endtask

  initial begin
    #(200_000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_arith();
    t_wrap();
    t_undef();
    t_halt_first();
    t_wrap_pc_and_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule